// File: doc/BRIEF.md
# CPU Clock Select and Oscillator Control

This block produces the CPU clock enable for a core whose clocks are all modelled as enables on one reference clock. The CPU clock is the main system clock passed through a power-of-two divider. A 3-bit ratio code selects the divider. Codes outside the legal set are refused. A new ratio waits for the end of the current divided period before it takes effect.

The block also reports which source feeds the CPU as a two-bit status pair (`cls`, `mcs`). It owns the run/stop line of the internal high-speed oscillator: software may stop that oscillator only while the CPU is on another source. A STOP-mode request halts the oscillator and gates the CPU enable. On wake-up, if the CPU runs from the external crystal clock, the enable stays gated for a programmable settle count.

The standby controller is a three-state machine:
- **SB_RUN**: normal operation.
  - `stop_req` moves it to SB_HALT (transition *enter-halt*).
- **SB_HALT**: the oscillator is off and the CPU enable is gated.
  - `wake` moves it to SB_SETTLE when the crystal is the CPU source (*wake-settle*).
  - Otherwise `wake` moves it straight to SB_RUN (*wake-direct*).
- **SB_SETTLE**: counts the settle value down.
  - It returns to SB_RUN when the count reaches zero (*settle-done*).

Top module: `cpuclk_ctrl`

## Requirements
- R1: After reset the ratio is code 1 (divide by 2), `cls`=0, `mcs`=0, `osc_en`=1 and `stab_busy`=0.
- R2: A write of ratio code c in 0..4 sets the divide factor N = 2^c (codes 000, 001, 010, 011, 100 give 1, 2, 4, 8, 16), so `cpu_ce` pulses once every N reference cycles.
- R3: A write of ratio code 5, 6 or 7 is ignored and the previous ratio stays in force.
- R4: A ratio change applies only at the end of the current divided period: the interval that is running when the write lands keeps the old length.
- R5: `cpu_ce` is a single reference-cycle pulse; for N greater than 1 it is low in the cycle after each pulse.
- R6: Each write takes effect one cycle later. `cls` follows the subsystem-select field. `mcs` follows the crystal-select field. Their meaning as {cls,mcs} is: 00 internal oscillator, 01 crystal (high-speed system clock), 1x subsystem clock.
- R7: A write with the stop field at 1 stops the internal oscillator (`osc_en`=0) only if `cls` or `mcs` was 1 before that write; if {cls,mcs} was 00 the request is refused and `osc_en` stays 1.
- R8: A write that selects the internal oscillator (subsystem=0, crystal=0), or that writes the stop field as 0, restarts the oscillator.
- R9: A `stop_req` pulse in SB_RUN enters SB_HALT: `osc_en` goes to 0 and `cpu_ce` stays low until a wake.
- R10: A `wake` in SB_HALT with {cls,mcs}=01 enters SB_SETTLE. `stab_busy` is 1 for exactly S+1 cycles, where S is the last written settle value. `cpu_ce` is low throughout. Afterwards `stab_busy` is 0 and pulses resume.
- R11: A `wake` in SB_HALT with any other source returns to SB_RUN at once without raising `stab_busy`.
- R12: `wake` outside SB_HALT has no effect: `stab_busy` stays 0 and the pulse period is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe; all fields below are written together |
| wr_ratio | input | 3 | Divide ratio code |
| wr_sub | input | 1 | Subsystem clock select |
| wr_x1 | input | 1 | Crystal (high-speed system) clock select for main clock |
| wr_ostop | input | 1 | Internal oscillator stop request |
| wr_stab | input | 8 | Oscillation settle count |
| stop_req | input | 1 | STOP-mode request pulse |
| wake | input | 1 | Wake event from STOP |
| cpu_ce | output | 1 | CPU clock enable pulse |
| cls | output | 1 | Status: CPU on subsystem clock |
| mcs | output | 1 | Status: main clock is the crystal |
| osc_en | output | 1 | Internal high-speed oscillator enable |
| stab_busy | output | 1 | Settle count running |

## Verification
The hardest case is a ratio write that lands partway through a long divided period. A wrong design would emit a shortened pulse there, so the stimulus must place the write at a known offset.
- The bench first selects divide-by-16, then waits for a pulse.
- It writes divide-by-1 three cycles later and counts cycles to the next pulse, which must still be 16.
- The following pulse must come one cycle after that.

The settle path needs the crystal selected and a settle value loaded before the STOP request. The bench then counts `stab_busy` cycles after the wake.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    localparam int RATIO_W   = 3;
    localparam int RATIO_TOP = 4;
    localparam int RATIO_RST = 1;
    localparam int SETTLE_W  = 8;

    typedef enum logic [1:0] {
        SB_RUN    = 2'd0,
        SB_HALT   = 2'd1,
        SB_SETTLE = 2'd2
    } sb_state_t;

    function automatic logic ratio_ok(input logic [RATIO_W-1:0] code, input int top);
        return (int'(code) <= top);
    endfunction

endpackage

// File: rtl/cpuclk_div.sv
module cpuclk_div
    import cpuclk_pkg::*;
#(
    parameter int CODE_W   = RATIO_W,
    parameter int CODE_TOP = RATIO_TOP,
    parameter int CODE_RST = RATIO_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] code_in,
    output logic              ce
);
    localparam int CNT_W = (CODE_TOP < 1) ? 1 : CODE_TOP;

    logic [CODE_W-1:0] pend_q, act_q, pend_nxt;
    logic [CNT_W-1:0]  cnt_q, lim;
    logic              tick;

    always_comb begin
        pend_nxt = pend_q;
        if (code_wr && ratio_ok(code_in, CODE_TOP))
            pend_nxt = code_in;
    end

    always_comb begin
        lim  = CNT_W'((1 << act_q) - 1);
        tick = run && (cnt_q == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= CODE_W'(CODE_RST);
            act_q  <= CODE_W'(CODE_RST);
            cnt_q  <= '0;
        end else begin
            pend_q <= pend_nxt;
            if (!run) begin
                cnt_q <= '0;
                act_q <= pend_nxt;
            end else if (tick) begin
                cnt_q <= '0;
                act_q <= pend_nxt;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ce = tick;

    AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(act_q) <= CODE_TOP); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && act_q != '0 && act_q == pend_nxt) |=> !ce); // R5
    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(act_q)); // R4

endmodule

// File: rtl/cpuclk_src.sv
module cpuclk_src
    import cpuclk_pkg::*;
#(
    parameter int STAB_W = SETTLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sub,
    input  logic              wr_x1,
    input  logic              wr_ostop,
    input  logic [STAB_W-1:0] wr_stab,
    output logic              cls,
    output logic              mcs,
    output logic              osc_stop,
    output logic [STAB_W-1:0] stab_val
);
    logic              sub_q, x1_q, rstop_q;
    logic [STAB_W-1:0] stab_q;
    logic              other_src, to_internal, stop_nxt;

    always_comb begin
        other_src   = sub_q || x1_q;
        to_internal = !wr_sub && !wr_x1;
        stop_nxt    = rstop_q;
        if (wr_en) begin
            if (to_internal || !wr_ostop)
                stop_nxt = 1'b0;
            else if (other_src)
                stop_nxt = 1'b1;
            else
                stop_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q   <= 1'b0;
            x1_q    <= 1'b0;
            rstop_q <= 1'b0;
            stab_q  <= '0;
        end else begin
            rstop_q <= stop_nxt;
            if (wr_en) begin
                sub_q  <= wr_sub;
                x1_q   <= wr_x1;
                stab_q <= wr_stab;
            end
        end
    end

    assign cls      = sub_q;
    assign mcs      = x1_q;
    assign osc_stop = rstop_q;
    assign stab_val = stab_q;

    AST_OSC_STOP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        rstop_q |-> (sub_q || x1_q)); // R7
    AST_STOP_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rstop_q) |-> $past(sub_q || x1_q)); // R7

endmodule

// File: rtl/cpuclk_stby.sv
module cpuclk_stby
    import cpuclk_pkg::*;
#(
    parameter int STAB_W = SETTLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              wake,
    input  logic              x1_active,
    input  logic [STAB_W-1:0] stab_val,
    output logic              run,
    output logic              halted,
    output logic              busy
);
    sb_state_t         st_q, st_nxt;
    logic [STAB_W-1:0] cnt_q;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            SB_RUN:    if (stop_req) st_nxt = SB_HALT;
            SB_HALT:   if (wake)     st_nxt = x1_active ? SB_SETTLE : SB_RUN;
            SB_SETTLE: if (cnt_q == '0) st_nxt = SB_RUN;
            default:   st_nxt = SB_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SB_RUN;
            cnt_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (st_q == SB_HALT)
                cnt_q <= stab_val;
            else if (st_q == SB_SETTLE && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        run    = 1'b0;
        halted = 1'b0;
        busy   = 1'b0;
        unique case (st_q)
            SB_RUN:    run    = 1'b1;
            SB_HALT:   halted = 1'b1;
            SB_SETTLE: busy   = 1'b1;
            default:   run    = 1'b0;
        endcase
    end

    AST_STOP_ENTERS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SB_RUN && stop_req) |=> st_q == SB_HALT); // R9
    AST_SETTLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SB_SETTLE && cnt_q == '0) |=> st_q == SB_RUN); // R10
    AST_WAKE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SB_HALT && wake && !x1_active) |=> st_q == SB_RUN); // R11
    AST_WAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SB_RUN && !stop_req) |=> st_q == SB_RUN); // R12

endmodule

// File: rtl/cpuclk_ctrl.sv
module cpuclk_ctrl
    import cpuclk_pkg::*;
#(
    parameter int CODE_W   = RATIO_W,
    parameter int CODE_TOP = RATIO_TOP,
    parameter int CODE_RST = RATIO_RST,
    parameter int STAB_W   = SETTLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_ratio,
    input  logic              wr_sub,
    input  logic              wr_x1,
    input  logic              wr_ostop,
    input  logic [STAB_W-1:0] wr_stab,
    input  logic              stop_req,
    input  logic              wake,
    output logic              cpu_ce,
    output logic              cls,
    output logic              mcs,
    output logic              osc_en,
    output logic              stab_busy
);
    logic              osc_stop, run, halted, busy, x1_active;
    logic [STAB_W-1:0] stab_val;

    cpuclk_src #(.STAB_W(STAB_W)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sub   (wr_sub),
        .wr_x1    (wr_x1),
        .wr_ostop (wr_ostop),
        .wr_stab  (wr_stab),
        .cls      (cls),
        .mcs      (mcs),
        .osc_stop (osc_stop),
        .stab_val (stab_val)
    );

    assign x1_active = mcs && !cls;

    cpuclk_stby #(.STAB_W(STAB_W)) u_stby (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_req  (stop_req),
        .wake      (wake),
        .x1_active (x1_active),
        .stab_val  (stab_val),
        .run       (run),
        .halted    (halted),
        .busy      (busy)
    );

    cpuclk_div #(
        .CODE_W   (CODE_W),
        .CODE_TOP (CODE_TOP),
        .CODE_RST (CODE_RST)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .code_wr (wr_en),
        .code_in (wr_ratio),
        .ce      (cpu_ce)
    );

    assign osc_en    = !osc_stop && !halted;
    assign stab_busy = busy;

    AST_SETTLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        stab_busy |-> !cpu_ce); // R10
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!cpu_ce && !osc_en)); // R9

endmodule

// File: tb/cpuclk_ctrl_test.sv
module cpuclk_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_ratio = 3'd1;
    logic       wr_sub = 1'b0, wr_x1 = 1'b0, wr_ostop = 1'b0;
    logic [7:0] wr_stab = 8'd0;
    logic       stop_req = 1'b0, wake = 1'b0;
    logic       cpu_ce, cls, mcs, osc_en, stab_busy;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [2:0] cur_code = 3'd1;

    // {code[2:0], expected period[4:0]}
    localparam logic [7:0] VEC [8] = '{
        {3'd0, 5'd1}, {3'd2, 5'd4}, {3'd5, 5'd4}, {3'd4, 5'd16},
        {3'd7, 5'd16}, {3'd3, 5'd8}, {3'd6, 5'd8}, {3'd1, 5'd2}
    };

    always #2 clk = ~clk;

    cpuclk_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ratio(wr_ratio),
        .wr_sub(wr_sub), .wr_x1(wr_x1), .wr_ostop(wr_ostop), .wr_stab(wr_stab),
        .stop_req(stop_req), .wake(wake), .cpu_ce(cpu_ce), .cls(cls),
        .mcs(mcs), .osc_en(osc_en), .stab_busy(stab_busy)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] code, input logic sub, input logic x1,
                      input logic ostop, input logic [7:0] stab);
        @(negedge clk);
        wr_en = 1'b1; wr_ratio = code; wr_sub = sub; wr_x1 = x1;
        wr_ostop = ostop; wr_stab = stab;
        if (code <= 3'd4) cur_code = code;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic period(output int n);
        int guard = 0;
        while (!cpu_ce && guard < 200) begin @(negedge clk); guard++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!cpu_ce && n < 200);
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int busy_n;
        int ce_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cls == 0 && mcs == 0, "R1 status", {cls, mcs}, 0);
        check(osc_en == 1, "R1 osc_en", osc_en, 1);
        check(stab_busy == 0, "R1 stab_busy", stab_busy, 0);
        period(n); period(n);
        check(n == 2, "R1 default period", n, 2);

        // R2/R3/R5 table walk
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][7:5], 1'b0, 1'b0, 1'b0, 8'd0);
            period(n); period(n);
            check(n == int'(VEC[i][4:0]), (VEC[i][7:5] > 4) ? "R3 prohibited code" : "R2 ratio period",
                  n, int'(VEC[i][4:0]));
        end

        // R4 change lands mid-period
        wr(3'd4, 1'b0, 1'b0, 1'b0, 8'd0);
        period(n);
        n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 3) begin wr_en = 1'b1; wr_ratio = 3'd0; cur_code = 3'd0; end
            else wr_en = 1'b0;
        end while (!cpu_ce && n < 100);
        wr_en = 1'b0;
        check(n == 16, "R4 old period kept", n, 16);
        @(negedge clk);
        check(cpu_ce == 1, "R4 new period after boundary", cpu_ce, 1);

        // R6 status encoding
        wr(cur_code, 1'b0, 1'b1, 1'b0, 8'd0);
        check({cls, mcs} == 2'b01, "R6 crystal", {cls, mcs}, 1);
        wr(cur_code, 1'b1, 1'b0, 1'b0, 8'd0);
        check({cls, mcs} == 2'b10, "R6 subsystem", {cls, mcs}, 2);
        wr(cur_code, 1'b1, 1'b1, 1'b0, 8'd0);
        check({cls, mcs} == 2'b11, "R6 subsystem over crystal", {cls, mcs}, 3);

        // R7 guard
        wr(cur_code, 1'b0, 1'b0, 1'b0, 8'd0);
        wr(cur_code, 1'b0, 1'b1, 1'b1, 8'd0);
        check(osc_en == 1, "R7 stop refused from internal", osc_en, 1);
        wr(cur_code, 1'b0, 1'b1, 1'b1, 8'd0);
        check(osc_en == 0, "R7 stop accepted on crystal", osc_en, 0);
        // R8 restart
        wr(cur_code, 1'b0, 1'b0, 1'b1, 8'd0);
        check(osc_en == 1 && {cls, mcs} == 2'b00, "R8 internal select restarts", osc_en, 1);
        wr(cur_code, 1'b1, 1'b0, 1'b1, 8'd0);
        wr(cur_code, 1'b1, 1'b0, 1'b0, 8'd0);
        check(osc_en == 1, "R8 stop field 0 restarts", osc_en, 1);

        // R9 STOP mode, R11 direct wake (subsystem source)
        wr(3'd1, 1'b1, 1'b0, 1'b0, 8'd0);
        pulse_stop();
        check(osc_en == 0, "R9 osc off in STOP", osc_en, 0);
        ce_seen = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); if (cpu_ce) ce_seen++; end
        check(ce_seen == 0, "R9 enable gated", ce_seen, 0);
        pulse_wake();
        check(stab_busy == 0 && osc_en == 1, "R11 direct wake", stab_busy, 0);
        period(n); period(n);
        check(n == 2, "R11 pulses resume", n, 2);

        // R10 settle after crystal wake
        wr(3'd1, 1'b0, 1'b1, 1'b0, 8'd5);
        pulse_stop();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        busy_n = 0; ce_seen = 0;
        while (stab_busy && busy_n < 300) begin
            if (cpu_ce) ce_seen++;
            busy_n++;
            @(negedge clk);
        end
        check(busy_n == 6, "R10 settle length", busy_n, 6);
        check(ce_seen == 0, "R10 gated during settle", ce_seen, 0);
        period(n);
        check(n == 2, "R10 pulses resume", n, 2);

        // R12 wake while running
        pulse_wake();
        check(stab_busy == 0, "R12 wake ignored busy", stab_busy, 0);
        period(n); period(n);
        check(n == 2, "R12 wake ignored period", n, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule